// File: doc/BRIEF.md
# Coprocessor Interrupt Pending and Gating Unit

This block keeps the interrupt state of a processor's system coprocessor: a Status word holding the per-line mask bits and the global enable, and a Cause word holding the pending bits. Eight pending bits sit in Cause bits 15:8. Line requests arrive as level events on a generic request channel. A dedicated level input from the external interrupt controller maps to line 2. A compare-timer pair maps to line 7: a match sets the line and a compare write clears it. Software can set the two software pending bits by writing Cause. It can write Status, and it can clear or set the global enable in one cycle. The clear and set operations return the previous Status word.

After every state change the block evaluates a single registered hard-interrupt request to the core. The request is high only when a pending bit is also unmasked, the global enable is set, and none of the three mode flags is active: exception level, error level and debug mode. The core never clears a pending bit by acknowledging the request. Pending lines are cleared only by their sources or by a register write.

Top module: `cop_irq_gate`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `status`, `cause`, `ie_old` and `irq` are all zero.
- R2: A request with `line_vld` high and `line_idx` below 16 writes `line_lvl` into Cause bit `line_idx`+8 at the next edge. A request with `line_idx` of 16 or more leaves `cause` unchanged.
- R3: After each edge, `irq` is 1 exactly when (status & cause & 0x0000FF00) is nonzero and status bit 0 (global enable) is 1, using the values just registered.
- R4: If any of `exc_lvl`, `err_lvl` or `dbg_mode` is high in a cycle, `irq` is 0 after the next edge. The flags are taken from the cycle before that edge.
- R5: A Status write (`sts_wr`) loads `wr_data & 0xFA78FF01` into `status`. The write takes priority over `ie_clr` and `ie_set` in the same cycle.
- R6: A Cause write (`cse_wr`) loads (C & 0xB000F87C) | (`wr_data` & 0x00C00300), where C is Cause after the same cycle's line events. Bits 9:8 and 23:22 come from the write, and bits outside both masks become 0.
- R7: Software pending bits set through a Cause write raise `irq` like hardware lines. Unmasking a line that is already pending raises `irq` at the next edge.
- R8: `ie_clr` clears status bit 0, and `ie_set` sets it if `ie_clr` is low. Either operation loads the Status value from before that edge into `ie_old`, which otherwise holds its value.
- R9: Whenever `pic_lvl` differs from its value in the previous cycle (the reset value is 0), Cause bit 10 takes the new level.
- R10: `tmr_hit` sets Cause bit 15. `cmp_wr` clears it and wins over `tmr_hit` in the same cycle.
- R11: Events in one cycle apply in a fixed order, and a later one overrides an earlier one on a shared bit: the generic request first, then the controller change, then the timer, then the Cause write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_vld | input | 1 | Generic line request strobe |
| line_idx | input | 5 | Line number of the request |
| line_lvl | input | 1 | Level carried by the request |
| pic_lvl | input | 1 | External controller request level (line 2) |
| tmr_hit | input | 1 | Count/compare match pulse (sets line 7) |
| cmp_wr | input | 1 | Compare register write pulse (clears line 7) |
| sts_wr | input | 1 | Status write strobe |
| cse_wr | input | 1 | Cause write strobe |
| wr_data | input | 32 | Data for Status or Cause writes |
| ie_clr | input | 1 | Clear global enable |
| ie_set | input | 1 | Set global enable |
| exc_lvl | input | 1 | Exception-level flag |
| err_lvl | input | 1 | Error-level flag |
| dbg_mode | input | 1 | Debug-mode flag |
| status | output | 32 | Registered Status word |
| cause | output | 32 | Registered Cause word |
| ie_old | output | 32 | Status value before the last enable/disable operation |
| irq | output | 1 | Registered hard-interrupt request |

## Verification
A wrong pending bit or mask bit shows up on `cause` or `status` one edge after the event that caused it. It also shows up on `irq` at that same edge whenever the gating conditions select that bit. The bench therefore compares all four outputs after every edge against a model computed from the requirements. The model sweeps all 32 line numbers, every pending-line and mask-line pair against every flag combination and both enable values, and the same-cycle collisions between sources. A gating fault is thus exposed within one cycle of the stimulus that exercises it.

// File: rtl/cop_irq_pkg.sv
package cop_irq_pkg;
  localparam int DATA_W   = 32;
  localparam int IP_LSB   = 8;
  localparam int IP_W     = 8;
  localparam int LINE_W   = 5;
  localparam int LINE_LIM = 16;
  localparam int PIC_LINE = 2;
  localparam int TMR_LINE = 7;
  localparam int IE_BIT   = 0;
  localparam logic [DATA_W-1:0] STS_WMASK  = 32'hFA78FF01;
  localparam logic [DATA_W-1:0] CSE_KEEP   = 32'hB000F87C;
  localparam logic [DATA_W-1:0] CSE_SWMASK = 32'h00C00300;

  function automatic logic [DATA_W-1:0] ip_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < IP_W; i++) m[IP_LSB+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cop_irq_lines.sv
module cop_irq_lines
  import cop_irq_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int LW   = LINE_W,
  parameter int LLIM = LINE_LIM,
  parameter int LSB  = IP_LSB,
  parameter int PICN = PIC_LINE,
  parameter int TMRN = TMR_LINE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] cause_q,
  input  logic          line_vld,
  input  logic [LW-1:0] line_idx,
  input  logic          line_lvl,
  input  logic          pic_lvl,
  input  logic          tmr_hit,
  input  logic          cmp_wr,
  output logic [DW-1:0] cause_ln
);
  localparam int TOP = LSB + LLIM;

  logic            pic_prev;
  logic            pic_chg;
  logic [LLIM-1:0] upd_bits;

  always_ff @(posedge clk) begin
    if (rst) pic_prev <= 1'b0;
    else     pic_prev <= pic_lvl;
  end

  assign pic_chg = (pic_lvl != pic_prev);

  for (genvar g = 0; g < LLIM; g++) begin : g_line
    logic hit, v_req, v_pic;
    assign hit   = line_vld && (line_idx == LW'(g));
    assign v_req = hit ? line_lvl : cause_q[LSB+g];
    if (g == PICN) begin : g_pic
      assign v_pic = pic_chg ? pic_lvl : v_req;
    end else begin : g_nopic
      assign v_pic = v_req;
    end
    if (g == TMRN) begin : g_tmr
      assign upd_bits[g] = cmp_wr ? 1'b0 : (tmr_hit ? 1'b1 : v_pic);
    end else begin : g_notmr
      assign upd_bits[g] = v_pic;
    end
  end

  if (TOP < DW) begin : g_hi
    assign cause_ln = {cause_q[DW-1:TOP], upd_bits, cause_q[LSB-1:0]};
  end else begin : g_nohi
    assign cause_ln = {upd_bits, cause_q[LSB-1:0]};
  end

  AST_HIGH_LINE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (line_vld && line_idx >= LW'(LLIM) && !pic_chg && !tmr_hit && !cmp_wr)
      |-> (cause_ln == cause_q)); // R2

  AST_CMP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |-> !cause_ln[LSB+TMRN]); // R10
endmodule

// File: rtl/cop_irq_regs.sv
module cop_irq_regs
  import cop_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IEB = IE_BIT,
  parameter logic [DW-1:0] SMASK = STS_WMASK,
  parameter logic [DW-1:0] KEEP  = CSE_KEEP,
  parameter logic [DW-1:0] SWM   = CSE_SWMASK
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] cause_ln,
  input  logic          sts_wr,
  input  logic          cse_wr,
  input  logic [DW-1:0] wr_data,
  input  logic          ie_clr,
  input  logic          ie_set,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] cause_q,
  output logic [DW-1:0] status_nxt,
  output logic [DW-1:0] cause_nxt,
  output logic [DW-1:0] ie_old_q
);
  always_comb begin
    status_nxt = status_q;
    if (sts_wr)      status_nxt = wr_data & SMASK;
    else if (ie_clr) status_nxt[IEB] = 1'b0;
    else if (ie_set) status_nxt[IEB] = 1'b1;
  end

  always_comb begin
    cause_nxt = cause_ln;
    if (cse_wr) cause_nxt = (cause_ln & KEEP) | (wr_data & SWM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      cause_q  <= '0;
      ie_old_q <= '0;
    end else begin
      status_q <= status_nxt;
      cause_q  <= cause_nxt;
      if (ie_clr || ie_set) ie_old_q <= status_q;
    end
  end

  AST_STS_WRITE_MASK: assert property (@(posedge clk) disable iff (rst)
    sts_wr |=> (status_q == ($past(wr_data) & SMASK))); // R5

  AST_IE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ie_clr && !sts_wr) |=> (!status_q[IEB] && ie_old_q == $past(status_q))); // R8

  AST_IE_SET: assert property (@(posedge clk) disable iff (rst)
    (ie_set && !ie_clr && !sts_wr) |=> (status_q[IEB] && ie_old_q == $past(status_q))); // R8

  AST_CSE_SW_BITS: assert property (@(posedge clk) disable iff (rst)
    cse_wr |=> ((cause_q & SWM) == ($past(wr_data) & SWM))); // R6
endmodule

// File: rtl/cop_irq_eval.sv
module cop_irq_eval
  import cop_irq_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int IEB = IE_BIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] status_nxt,
  input  logic [DW-1:0] cause_nxt,
  input  logic [DW-1:0] status_q,
  input  logic [DW-1:0] cause_q,
  input  logic          exc_lvl,
  input  logic          err_lvl,
  input  logic          dbg_mode,
  output logic          irq_q
);
  localparam logic [DW-1:0] IPM = ip_mask();

  logic pend_any, mode_blk, req_d;

  assign pend_any = |(status_nxt & cause_nxt & IPM);
  assign mode_blk = exc_lvl | err_lvl | dbg_mode;
  assign req_d    = pend_any & status_nxt[IEB] & ~mode_blk;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= req_d;
  end

  AST_IRQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (status_q[IEB] && (|(status_q & cause_q & IPM)))); // R3

  AST_MODE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (exc_lvl || err_lvl || dbg_mode) |=> !irq_q); // R4
endmodule

// File: rtl/cop_irq_gate.sv
module cop_irq_gate
  import cop_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int LW = LINE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_vld,
  input  logic [LW-1:0] line_idx,
  input  logic          line_lvl,
  input  logic          pic_lvl,
  input  logic          tmr_hit,
  input  logic          cmp_wr,
  input  logic          sts_wr,
  input  logic          cse_wr,
  input  logic [DW-1:0] wr_data,
  input  logic          ie_clr,
  input  logic          ie_set,
  input  logic          exc_lvl,
  input  logic          err_lvl,
  input  logic          dbg_mode,
  output logic [DW-1:0] status,
  output logic [DW-1:0] cause,
  output logic [DW-1:0] ie_old,
  output logic          irq
);
  logic [DW-1:0] cause_ln, status_nxt, cause_nxt;

  cop_irq_lines #(.DW(DW), .LW(LW)) u_lines (
    .clk(clk), .rst(rst), .cause_q(cause),
    .line_vld(line_vld), .line_idx(line_idx), .line_lvl(line_lvl),
    .pic_lvl(pic_lvl), .tmr_hit(tmr_hit), .cmp_wr(cmp_wr),
    .cause_ln(cause_ln)
  );

  cop_irq_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .cause_ln(cause_ln),
    .sts_wr(sts_wr), .cse_wr(cse_wr), .wr_data(wr_data),
    .ie_clr(ie_clr), .ie_set(ie_set),
    .status_q(status), .cause_q(cause),
    .status_nxt(status_nxt), .cause_nxt(cause_nxt), .ie_old_q(ie_old)
  );

  cop_irq_eval #(.DW(DW)) u_eval (
    .clk(clk), .rst(rst),
    .status_nxt(status_nxt), .cause_nxt(cause_nxt),
    .status_q(status), .cause_q(cause),
    .exc_lvl(exc_lvl), .err_lvl(err_lvl), .dbg_mode(dbg_mode),
    .irq_q(irq)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (status == '0 && cause == '0 && !irq)); // R1
endmodule

// File: tb/cop_irq_gate_tb_top.sv
module cop_irq_gate_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_vld = 0, line_lvl = 0, pic_lvl = 0, tmr_hit = 0, cmp_wr = 0;
  logic sts_wr = 0, cse_wr = 0, ie_clr = 0, ie_set = 0;
  logic exc_lvl = 0, err_lvl = 0, dbg_mode = 0;
  logic [4:0]  line_idx = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] status, cause, ie_old;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_st = 0, m_ca = 0, m_old = 0;
  logic        m_irq = 0, m_pic = 0;

  always #10 clk = ~clk;

  cop_irq_gate dut_i (
    .clk(clk), .rst(rst), .line_vld(line_vld), .line_idx(line_idx),
    .line_lvl(line_lvl), .pic_lvl(pic_lvl), .tmr_hit(tmr_hit), .cmp_wr(cmp_wr),
    .sts_wr(sts_wr), .cse_wr(cse_wr), .wr_data(wr_data),
    .ie_clr(ie_clr), .ie_set(ie_set), .exc_lvl(exc_lvl), .err_lvl(err_lvl),
    .dbg_mode(dbg_mode), .status(status), .cause(cause), .ie_old(ie_old), .irq(irq)
  );

  task automatic chk(input string tag);
    n_chk++;
    if (status !== m_st || cause !== m_ca || ie_old !== m_old || irq !== m_irq) begin
      n_bad++;
      $display("FAIL %s: st=%h ca=%h old=%h irq=%b exp st=%h ca=%h old=%h irq=%b",
               tag, status, cause, ie_old, irq, m_st, m_ca, m_old, m_irq);
    end
  endtask

  task automatic model_edge();
    logic [31:0] ca, st;
    ca = m_ca; st = m_st;
    if (rst) begin
      m_st = 0; m_ca = 0; m_old = 0; m_irq = 0; m_pic = 0;
      return;
    end
    if (line_vld && line_idx < 16) ca[line_idx + 8] = line_lvl;   // R2, R11 order
    if (pic_lvl != m_pic) ca[10] = pic_lvl;                       // R9
    m_pic = pic_lvl;
    if (tmr_hit) ca[15] = 1'b1;                                   // R10
    if (cmp_wr)  ca[15] = 1'b0;
    if (cse_wr)  ca = (ca & 32'hB000F87C) | (wr_data & 32'h00C00300); // R6
    if (sts_wr)      st = wr_data & 32'hFA78FF01;                 // R5
    else if (ie_clr) st[0] = 1'b0;                                // R8
    else if (ie_set) st[0] = 1'b1;
    if (ie_clr || ie_set) m_old = m_st;
    m_irq = ((st & ca & 32'h0000FF00) != 0) && st[0] && !(exc_lvl || err_lvl || dbg_mode);
    m_st = st; m_ca = ca;
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag);
    line_vld = 0; tmr_hit = 0; cmp_wr = 0; sts_wr = 0; cse_wr = 0;
    ie_clr = 0; ie_set = 0;
  endtask

  task automatic req(input int idx, input logic lvl);
    line_vld = 1; line_idx = 5'(idx); line_lvl = lvl;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
  end

  initial begin
    @(negedge clk);
    cyc("R1 reset");
    cyc("R1 reset");
    rst = 0;
    cyc("R1 first cycle after reset");

    // R2: every line number, set then clear
    for (int i = 0; i < 32; i++) begin
      req(i, 1'b1); cyc("R2 line set");
      req(i, 1'b0); cyc("R2 line clear");
    end
    // R2: high line on top of pending state
    req(3, 1); cyc("R2 prep");
    req(20, 0); cyc("R2 high line ignored");
    req(31, 1); cyc("R2 high line ignored");
    req(3, 0); cyc("R2 cleanup");

    // R5: status write masking
    foreach (wr_data[b]) begin
      sts_wr = 1; wr_data = 32'h1 << b; cyc("R5 status bit");
    end
    sts_wr = 1; wr_data = 32'hFFFFFFFF; cyc("R5 status all ones");
    sts_wr = 1; wr_data = 32'h0; cyc("R5 status zero");

    // R6: cause write merge
    req(5, 1); cyc("R6 prep");
    req(12, 1); cyc("R6 prep");
    cse_wr = 1; wr_data = 32'hFFFFFFFF; cyc("R6 cause all ones");
    cse_wr = 1; wr_data = 32'h00400100; cyc("R6 cause partial");
    cse_wr = 1; wr_data = 32'h0; cyc("R6 cause zero");
    req(5, 0); cyc("R6 cleanup");

    // R3/R4: pending line x mask line x flags x enable
    for (int p = 0; p < 8; p++)
      for (int m = 0; m < 8; m++)
        for (int f = 0; f < 8; f++)
          for (int e = 0; e < 2; e++) begin
            req(p, 1'b1); sts_wr = 1; wr_data = (32'h100 << m) | 32'(e);
            {exc_lvl, err_lvl, dbg_mode} = 3'(f);
            cyc("R3 R4 gating");
            exc_lvl = 0; err_lvl = 0; dbg_mode = 0;
            req(p, 1'b0); cyc("R3 line released");
          end

    // R7: software pending and late unmask
    sts_wr = 1; wr_data = 32'h0000_0001; cyc("R7 enable only");
    cse_wr = 1; wr_data = 32'h0000_0200; cyc("R7 soft pending masked");
    sts_wr = 1; wr_data = 32'h0000_0201; cyc("R7 unmask raises irq");
    cse_wr = 1; wr_data = 32'h0; cyc("R7 soft clear drops irq");

    // R8: enable clear/set and priority
    sts_wr = 1; wr_data = 32'h0000_FF01; cyc("R8 prep");
    req(4, 1); cyc("R8 pending");
    ie_clr = 1; cyc("R8 disable");
    ie_set = 1; cyc("R8 enable");
    ie_clr = 1; ie_set = 1; cyc("R8 clear wins over set");
    ie_set = 1; sts_wr = 1; wr_data = 32'h0000_1000; cyc("R8 status write wins");
    ie_set = 1; cyc("R8 enable again");
    req(4, 0); cyc("R8 cleanup");

    // R9: controller line
    sts_wr = 1; wr_data = 32'h0000_0401; cyc("R9 prep");
    pic_lvl = 1; cyc("R9 controller raise");
    cyc("R9 controller hold");
    cse_wr = 1; wr_data = 32'h0; cyc("R9 cause write drops bit 10");
    cyc("R9 steady level no re-set");
    pic_lvl = 0; cyc("R9 controller low");
    pic_lvl = 1; req(2, 0); cyc("R11 controller beats request");
    pic_lvl = 0; cyc("R9 controller low");

    // R10: timer
    sts_wr = 1; wr_data = 32'h0000_8001; cyc("R10 prep");
    tmr_hit = 1; cyc("R10 match sets");
    cmp_wr = 1; cyc("R10 compare write clears");
    tmr_hit = 1; cmp_wr = 1; cyc("R10 clear wins");
    req(7, 1); cmp_wr = 1; cyc("R11 timer beats request");
    tmr_hit = 1; req(7, 0); cyc("R11 timer beats request clear");
    cmp_wr = 1; cyc("R10 cleanup");

    // R11: cause write overrides a request on a software bit
    req(1, 1); cse_wr = 1; wr_data = 32'h0; cyc("R11 cause write beats request");
    req(0, 0); cse_wr = 1; wr_data = 32'h100; cyc("R11 cause write sets soft bit");

    rst = 1; cyc("R1 reset mid run");
    rst = 0; cyc("R1 after reset");
    summary();
  end
endmodule